// File: doc/BRIEF.md
# Configurable Logic-Array Output Cell

This block is one output cell of a programmable logic array. It receives product terms that the array has already evaluated. Twelve of them are logic terms, and the rest are per-register control terms: a clock term and an asynchronous clear term for each register, plus an output-enable term for the pad. It also receives a group-wide synchronous set line, a global clock pin and the value seen at the pad. Static configuration inputs decide how the logic terms are grouped into OR sums and where those sums go:

- to the pad directly, or through the first register;
- to a buried second register;
- or, in place of that register, to a buried combinational node.

Each register can work as a D-type or a T-type flip-flop. Each register picks its own clock source. The whole cell runs on one system clock. A register "clock" is therefore the rising edge of its chosen source, found by sampling that source on the system clock. The cell returns four feedback signals to the array: the pad value, the first register with its polarity matched to the pad, the first register raw, and the second register or buried node.

Top module: `pld_macrocell`

## Requirements
- R1: With `cfg_merge`=2 (all) and `cfg_out_reg`=0, `pad_out` is the OR of all twelve `logic_terms`, inverted when `cfg_inv`=1.
- R2: With `cfg_merge`=1 (pair), bits 7..0 form one sum that drives the pad path. Bits 11..8 form the sum loaded into the second register.
- R3: With `cfg_merge`=0 (split) and combinational output, bits 3..0 drive the pad, bits 7..4 load the first register and bits 11..8 load the second.
- R4: With `cfg_out_reg`=1, the first register loads the pad-path sum and `pad_out` shows its state (after polarity), changing only when that register is clocked.
- R5: A register with its toggle bit set inverts its state on a clock when its input sum is 1 and holds it when the sum is 0.
- R6: Clock select per register: 0 means a rising edge of its clock term, 1 means a rising edge of `sync_clk_pin`, 2 means a rising edge of `sync_clk_pin` while its clock term is 1. Edges from any source that is not selected have no effect.
- R7: A register's clear term forces its feedback to 0 in the same cycle it is raised. A clear held across a system clock edge leaves the register at 0.
- R8: `sync_preset` sets a register to 1 only on a clock that register receives. The set wins over the D/T value, and a clear wins over the set.
- R9: `pad_oe` follows `oe_term`, and `fb_pin` always returns `pad_in`, including when the pad is used as an input.
- R10: With `cfg_q2_comb`=1, `fb_q2` is the sum of bits 11..8 with no clock involved.
- R11: `fb_q1` is the first register XOR `cfg_inv`, and `fb_q1_raw` is the register state regardless of polarity.
- R12: After `rst_n` is released, both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| cfg_merge | input | 2 | sum grouping: 0 split, 1 pair, 2 all |
| cfg_out_reg | input | 1 | 1 = pad driven by first register |
| cfg_inv | input | 1 | output polarity invert |
| cfg_q2_comb | input | 1 | 1 = second position is a combinational node |
| cfg_q1_toggle | input | 1 | first register T-type |
| cfg_q2_toggle | input | 1 | second register T-type |
| cfg_q1_clk | input | 2 | first register clock source |
| cfg_q2_clk | input | 2 | second register clock source |
| logic_terms | input | 3*TERMS_PER_SUM | evaluated logic product terms |
| q1_clk_term | input | 1 | first register clock term |
| q2_clk_term | input | 1 | second register clock term |
| q1_ar_term | input | 1 | first register clear term |
| q2_ar_term | input | 1 | second register clear term |
| oe_term | input | 1 | pad output-enable term |
| sync_preset | input | 1 | group synchronous set |
| sync_clk_pin | input | 1 | global clock pin |
| pad_in | input | 1 | value seen at the pad |
| pad_out | output | 1 | data toward the pad |
| pad_oe | output | 1 | pad drive enable |
| fb_pin | output | 1 | pad feedback |
| fb_q1 | output | 1 | first register, polarity matched |
| fb_q1_raw | output | 1 | first register, raw |
| fb_q2 | output | 1 | second register or buried node |

## Verification
The bench builds the cell with its default parameters. `TERMS_PER_SUM`=4 gives the twelve-bit term vector whose bit ranges the requirements name. `HAS_BURIED_COMB`=1 keeps the combinational node variant in the design, so both the clocked and the unclocked second position can be tested. Every grouping, both output modes, all three clock selections and the clear/set/data priority order are each driven from a single configuration.

// File: rtl/mc_pkg.sv
package mc_pkg;
   typedef enum logic [1:0] {
      MG_SPLIT = 2'd0,
      MG_PAIR  = 2'd1,
      MG_ALL   = 2'd2
   } merge_e;

   typedef enum logic [1:0] {
      CK_TERM  = 2'd0,
      CK_PIN   = 2'd1,
      CK_GATED = 2'd2
   } clk_e;

   localparam int unsigned NUM_SUMS = 3;
endpackage

// File: rtl/mc_sum_router.sv
module mc_sum_router
   import mc_pkg::*;
#(
   parameter int unsigned TERMS_PER_SUM = 4,
   localparam int unsigned NT = NUM_SUMS * TERMS_PER_SUM
) (
   input  logic [NT-1:0] terms,
   input  logic [1:0]    merge,
   output logic          grp_a,
   output logic          grp_b,
   output logic          grp_c
);
   logic [NUM_SUMS-1:0] sums;

   for (genvar g = 0; g < NUM_SUMS; g++) begin : g_sum
      assign sums[g] = |terms[g*TERMS_PER_SUM +: TERMS_PER_SUM];
   end

   always_comb begin
      case (merge_e'(merge))
         MG_SPLIT: begin
            grp_a = sums[0];
            grp_b = sums[1];
            grp_c = sums[2];
         end
         MG_PAIR: begin
            grp_a = sums[0] | sums[1];
            grp_b = 1'b0;
            grp_c = sums[2];
         end
         default: begin
            grp_a = |sums;
            grp_b = 1'b0;
            grp_c = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/mc_flop.sv
module mc_flop
   import mc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       d,
   input  logic       toggle,
   input  logic [1:0] clk_sel,
   input  logic       clk_term,
   input  logic       sync_pin,
   input  logic       ar,
   input  logic       sp,
   output logic       q
);
   logic q_state;
   logic term_d, pin_d;
   logic fire;

   always_comb begin
      case (clk_e'(clk_sel))
         CK_TERM:  fire = clk_term & ~term_d;
         CK_PIN:   fire = sync_pin & ~pin_d;
         CK_GATED: fire = sync_pin & ~pin_d & clk_term;
         default:  fire = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         term_d  <= 1'b0;
         pin_d   <= 1'b0;
         q_state <= 1'b0;
      end else begin
         term_d <= clk_term;
         pin_d  <= sync_pin;
         if (ar)
            q_state <= 1'b0;
         else if (fire)
            q_state <= sp ? 1'b1 : (toggle ? (q_state ^ d) : d);
      end
   end

   assign q = ar ? 1'b0 : q_state;

   p_clear_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ar |=> (q_state == 1'b0));
   p_no_edge_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire && !ar) |=> (q_state == $past(q_state)));
   p_preset_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && sp && !ar) |=> q_state);
   p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !sp && !ar && toggle && d) |=> (q_state != $past(q_state)));
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
   import mc_pkg::*;
#(
   parameter int unsigned TERMS_PER_SUM   = 4,
   parameter bit          HAS_BURIED_COMB = 1'b1,
   localparam int unsigned NT = NUM_SUMS * TERMS_PER_SUM
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    cfg_merge,
   input  logic          cfg_out_reg,
   input  logic          cfg_inv,
   input  logic          cfg_q2_comb,
   input  logic          cfg_q1_toggle,
   input  logic          cfg_q2_toggle,
   input  logic [1:0]    cfg_q1_clk,
   input  logic [1:0]    cfg_q2_clk,
   input  logic [NT-1:0] logic_terms,
   input  logic          q1_clk_term,
   input  logic          q2_clk_term,
   input  logic          q1_ar_term,
   input  logic          q2_ar_term,
   input  logic          oe_term,
   input  logic          sync_preset,
   input  logic          sync_clk_pin,
   input  logic          pad_in,
   output logic          pad_out,
   output logic          pad_oe,
   output logic          fb_pin,
   output logic          fb_q1,
   output logic          fb_q1_raw,
   output logic          fb_q2
);
   if (TERMS_PER_SUM < 1 || TERMS_PER_SUM > 16) begin : g_bad_terms
      $error("pld_macrocell: TERMS_PER_SUM must be within 1..16");
   end

   logic grp_a, grp_b, grp_c;
   logic q1, q2;
   logic d1;

   mc_sum_router #(.TERMS_PER_SUM(TERMS_PER_SUM)) u_route (
      .terms (logic_terms),
      .merge (cfg_merge),
      .grp_a (grp_a),
      .grp_b (grp_b),
      .grp_c (grp_c)
   );

   assign d1 = cfg_out_reg ? grp_a : grp_b;

   mc_flop u_q1 (
      .clk      (clk),
      .rst_n    (rst_n),
      .d        (d1),
      .toggle   (cfg_q1_toggle),
      .clk_sel  (cfg_q1_clk),
      .clk_term (q1_clk_term),
      .sync_pin (sync_clk_pin),
      .ar       (q1_ar_term),
      .sp       (sync_preset),
      .q        (q1)
   );

   mc_flop u_q2 (
      .clk      (clk),
      .rst_n    (rst_n),
      .d        (grp_c),
      .toggle   (cfg_q2_toggle),
      .clk_sel  (cfg_q2_clk),
      .clk_term (q2_clk_term),
      .sync_pin (sync_clk_pin),
      .ar       (q2_ar_term),
      .sp       (sync_preset),
      .q        (q2)
   );

   assign pad_out   = (cfg_out_reg ? q1 : grp_a) ^ cfg_inv;
   assign pad_oe    = oe_term;
   assign fb_pin    = pad_in;
   assign fb_q1     = q1 ^ cfg_inv;
   assign fb_q1_raw = q1;

   if (HAS_BURIED_COMB) begin : g_node
      assign fb_q2 = cfg_q2_comb ? grp_c : q2;
   end else begin : g_reg_only
      assign fb_q2 = q2;
   end

   p_regout_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_out_reg |-> (pad_out == (fb_q1_raw ^ cfg_inv)));
endmodule

// File: tb/sim_pld_macrocell.sv
module sim_pld_macrocell;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_merge = 2'd0;
   logic        cfg_out_reg = 1'b0, cfg_inv = 1'b0, cfg_q2_comb = 1'b0;
   logic        cfg_q1_toggle = 1'b0, cfg_q2_toggle = 1'b0;
   logic [1:0]  cfg_q1_clk = 2'd1, cfg_q2_clk = 2'd1;
   logic [11:0] logic_terms = '0;
   logic        q1_clk_term = 1'b0, q2_clk_term = 1'b0;
   logic        q1_ar_term = 1'b0, q2_ar_term = 1'b0;
   logic        oe_term = 1'b0, sync_preset = 1'b0, sync_clk_pin = 1'b0, pad_in = 1'b0;
   logic        pad_out, pad_oe, fb_pin, fb_q1, fb_q1_raw, fb_q2;
   int total = 0, bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pld_macrocell u0 (
      .clk(clk), .rst_n(rst_n), .cfg_merge(cfg_merge), .cfg_out_reg(cfg_out_reg),
      .cfg_inv(cfg_inv), .cfg_q2_comb(cfg_q2_comb), .cfg_q1_toggle(cfg_q1_toggle),
      .cfg_q2_toggle(cfg_q2_toggle), .cfg_q1_clk(cfg_q1_clk), .cfg_q2_clk(cfg_q2_clk),
      .logic_terms(logic_terms), .q1_clk_term(q1_clk_term), .q2_clk_term(q2_clk_term),
      .q1_ar_term(q1_ar_term), .q2_ar_term(q2_ar_term), .oe_term(oe_term),
      .sync_preset(sync_preset), .sync_clk_pin(sync_clk_pin), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .fb_pin(fb_pin), .fb_q1(fb_q1),
      .fb_q1_raw(fb_q1_raw), .fb_q2(fb_q2)
   );

   task automatic chk(input string req, input logic got, input logic exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_pin();
      sync_clk_pin = 1'b1;
      tick();
      sync_clk_pin = 1'b0;
      tick();
   endtask

   task automatic clear_both();
      q1_ar_term = 1'b1;
      q2_ar_term = 1'b1;
      tick();
      q1_ar_term = 1'b0;
      q2_ar_term = 1'b0;
      tick();
   endtask

   task automatic setup(input logic [1:0] mg, input logic oreg, input logic inv);
      cfg_merge = mg; cfg_out_reg = oreg; cfg_inv = inv;
      cfg_q2_comb = 1'b0; cfg_q1_toggle = 1'b0; cfg_q2_toggle = 1'b0;
      cfg_q1_clk = 2'd1; cfg_q2_clk = 2'd1;
      logic_terms = '0; sync_preset = 1'b0;
      clear_both();
   endtask

   task automatic t_reset();
      chk("R12 q1 after reset", fb_q1_raw, 1'b0);
      chk("R12 q2 after reset", fb_q2, 1'b0);
   endtask

   task automatic t_merge_all();
      setup(2'd2, 1'b0, 1'b0);
      chk("R1 no term", pad_out, 1'b0);
      for (int i = 0; i < 12; i++) begin
         logic_terms = 12'd1 << i;
         #1 chk("R1 single term", pad_out, 1'b1);
      end
      cfg_inv = 1'b1;
      #1 chk("R1 inverted one", pad_out, 1'b0);
      logic_terms = '0;
      #1 chk("R1 inverted zero", pad_out, 1'b1);
      tick();
   endtask

   task automatic t_merge_pair();
      setup(2'd1, 1'b0, 1'b0);
      logic_terms = 12'h080;
      #1 chk("R2 bit7 to pad", pad_out, 1'b1);
      logic_terms = 12'h100;
      #1 chk("R2 bit8 off pad", pad_out, 1'b0);
      tick();
      pulse_pin();
      chk("R2 bit8 to q2", fb_q2, 1'b1);
      chk("R2 q1 empty", fb_q1_raw, 1'b0);
   endtask

   task automatic t_split();
      setup(2'd0, 1'b0, 1'b0);
      logic_terms = 12'h010;
      #1 chk("R3 bit4 off pad", pad_out, 1'b0);
      tick();
      pulse_pin();
      chk("R3 bit4 to q1", fb_q1_raw, 1'b1);
      chk("R3 q2 idle", fb_q2, 1'b0);
      logic_terms = 12'h004;
      #1 chk("R3 bit2 to pad", pad_out, 1'b1);
      tick();
   endtask

   task automatic t_regout();
      setup(2'd1, 1'b1, 1'b0);
      logic_terms = 12'h020;
      tick();
      chk("R4 pad waits for clock", pad_out, 1'b0);
      pulse_pin();
      chk("R4 pad shows q1", pad_out, 1'b1);
      cfg_inv = 1'b1;
      #1 chk("R4 pad inverted", pad_out, 1'b0);
      chk("R11 matched fb", fb_q1, 1'b0);
      chk("R11 raw fb", fb_q1_raw, 1'b1);
      tick();
   endtask

   task automatic t_toggle();
      setup(2'd0, 1'b0, 1'b0);
      cfg_q1_toggle = 1'b1;
      logic_terms = 12'h010;
      pulse_pin(); chk("R5 toggle 1", fb_q1_raw, 1'b1);
      pulse_pin(); chk("R5 toggle 2", fb_q1_raw, 1'b0);
      pulse_pin(); chk("R5 toggle 3", fb_q1_raw, 1'b1);
      logic_terms = '0;
      pulse_pin(); chk("R5 hold", fb_q1_raw, 1'b1);
   endtask

   task automatic t_clocks();
      setup(2'd0, 1'b0, 1'b0);
      cfg_q1_clk = 2'd0;
      logic_terms = 12'h010;
      pulse_pin();
      chk("R6 pin ignored in term mode", fb_q1_raw, 1'b0);
      q1_clk_term = 1'b1;
      tick();
      chk("R6 term edge loads", fb_q1_raw, 1'b1);
      q1_clk_term = 1'b0;
      clear_both();
      cfg_q1_clk = 2'd2;
      pulse_pin();
      chk("R6 gated off", fb_q1_raw, 1'b0);
      q1_clk_term = 1'b1;
      tick();
      chk("R6 term alone no clock", fb_q1_raw, 1'b0);
      pulse_pin();
      chk("R6 gated on", fb_q1_raw, 1'b1);
      q1_clk_term = 1'b0;
      tick();
   endtask

   task automatic t_clear();
      setup(2'd0, 1'b0, 1'b0);
      logic_terms = 12'h010;
      pulse_pin();
      chk("R7 loaded before clear", fb_q1_raw, 1'b1);
      q1_ar_term = 1'b1;
      #1 chk("R7 immediate clear", fb_q1_raw, 1'b0);
      tick();
      q1_ar_term = 1'b0;
      #1 chk("R7 stays clear", fb_q1_raw, 1'b0);
      tick();
   endtask

   task automatic t_preset();
      setup(2'd0, 1'b0, 1'b0);
      sync_preset = 1'b1;
      tick(); tick();
      chk("R8 no preset without clock", fb_q1_raw, 1'b0);
      pulse_pin();
      chk("R8 preset beats data 0", fb_q1_raw, 1'b1);
      clear_both();
      q1_ar_term = 1'b1;
      sync_clk_pin = 1'b1;
      tick();
      sync_clk_pin = 1'b0;
      q1_ar_term = 1'b0;
      tick();
      chk("R8 clear beats preset", fb_q1_raw, 1'b0);
      sync_preset = 1'b0;
   endtask

   task automatic t_oe();
      oe_term = 1'b0; pad_in = 1'b1;
      #1 chk("R9 oe off", pad_oe, 1'b0);
      chk("R9 pad input fed back", fb_pin, 1'b1);
      oe_term = 1'b1; pad_in = 1'b0;
      #1 chk("R9 oe on", pad_oe, 1'b1);
      chk("R9 pad low fed back", fb_pin, 1'b0);
      tick();
   endtask

   task automatic t_node();
      setup(2'd0, 1'b0, 1'b0);
      cfg_q2_comb = 1'b1;
      logic_terms = 12'h200;
      #1 chk("R10 node follows sum", fb_q2, 1'b1);
      logic_terms = '0;
      #1 chk("R10 node drops", fb_q2, 1'b0);
      tick();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_merge_all();
      t_merge_pair();
      t_split();
      t_regout();
      t_toggle();
      t_clocks();
      t_clear();
      t_preset();
      t_oe();
      t_node();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got hung expected finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule